// File: doc/BRIEF.md
# Context State Memory with Forwarding

This block keeps the adaptive probability state of every coding context for a binary arithmetic coder. Each accepted input is a context label and a decision bit. The block looks up that context's predicted symbol and probability state. It reports whether the decision matched the prediction, and it sends the probability estimate of the current state to the interval stage that follows. It also computes the successor state and writes it back into the context store, so the next use of that context sees the adapted estimate.

The pipeline never stalls for a read-after-write hazard. It has two forwarding cases:

- **Next cycle.** A context that comes back in the very next cycle takes the freshly computed state straight from the update logic. A second copy of the probability table, indexed by the successor state, supplies that state's row.
- **Two cycles later.** A context that comes back two cycles later reads the store after the write has landed.

The state table is the standard 47-row probability table of the JPEG 2000 arithmetic coder. Context labels are 5 bits wide and 19 contexts are stored.

The stream rules are as follows:

- Both the input and the output are valid/ready. `in_ready` follows `out_ready` unless reset or `init` is active.
- The whole pipeline advances only in cycles where `out_ready` is high. When the consumer holds `out_ready` low, nothing moves. A presented output keeps its value until it is taken.
- An `init` pulse restores every context to its start state and drops all in-flight entries.

Top module: `ctx_state_bypass`

## Requirements
- R1: After reset, every context has prediction 0 and state 0, except two: context 17 starts in state 3 and context 18 starts in state 46. Consequently:
  - the first decision 0 on context 0 yields probability 0x5601 with the MPS flag 1;
  - the same on context 17 yields 0x0AC1 with the flag 1;
  - decision 1 on context 18 yields 0x5601 with the flag 0.
- R2: For each accepted input, one output appears with a latency of exactly two advancing cycles. An input accepted at clock edge k is presented after edge k+2 when `out_ready` is high. The output carries the 16-bit probability of the context's current state, and `out_is_mps` = 1 when the decision equals the stored prediction.
- R3: State updates follow the table:
  - A match moves the context to the state's next-on-MPS index.
  - A mismatch moves it to the next-on-LPS index, and the prediction inverts when that state's switch flag is set.
  - Sample table rows (probability, next-on-MPS, next-on-LPS): state 0 = 0x5601/1/1 with switch set; 1 = 0x3401/2/6; 2 = 0x1801/3/9; 9 = 0x3801/10/14; 10 = 0x3001/11/17; 17 = 0x4801/18/16; 46 = 0x5601/46/46.
- R4: A context repeated on consecutive accepted inputs sees the state left by its predecessor, and `in_ready` stays high throughout.
- R5: A context repeated with one other input in between also sees its predecessor's update.
- R6: Back-pressure rules:
  - `in_ready` is low whenever `out_ready` is low.
  - While `out_ready` is low, `out_valid`, `out_prob` and `out_is_mps` hold their values.
  - An input presented while `in_ready` is low is not taken and creates no output.
  - After reset, `out_valid` is 0 and `in_ready` is 1 when `out_ready` is 1.
- R7: An `init` pulse:
  - holds `in_ready` low in its cycle;
  - discards every in-flight entry, so `out_valid` stays 0 until new input arrives;
  - restores all contexts to the R1 start states.
- R8: A label of 19 or above is coded as context 18. It gives probability 0x5601 with prediction 0 and changes no other context.
- R9: For long random streams with heavy same-context repetition and random back-pressure, every output equals a model that updates the states in strict input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init | input | 1 | Restores all context states and flushes the pipeline |
| in_valid | input | 1 | Input pair is offered |
| in_ready | output | 1 | Input pair is taken when high together with in_valid |
| in_ctx | input | CTX_W | Context label |
| in_bit | input | 1 | Decision to be coded |
| out_valid | output | 1 | Output result is presented |
| out_ready | input | 1 | Consumer takes the output; also advances the pipeline |
| out_prob | output | 16 | Probability estimate of the state used |
| out_is_mps | output | 1 | 1 when the decision equalled the prediction |

## Verification
Two events can land in the same clock edge: a context's write-back into the store, and the lookup of that same context by the next input. That collision is where forwarding must replace the stale stored value. It is provoked by runs of one label, alternating pairs of labels, and a random stream that repeats the previous label half of the time while `out_ready` is toggled at random. Stalls therefore also fall between a write-back and its dependent lookup. Each output is judged against a model that applies the table in input order. Directed cases compare against literal table values, and a timing check confirms that a run of repeats takes one cycle per input.

// File: rtl/ctxs_pkg.sv
package ctxs_pkg;
  localparam int PROB_W     = 16;
  localparam int IDX_W      = 6;
  localparam int NUM_STATES = 47;

  typedef struct packed {
    logic [PROB_W-1:0] qe;
    logic [IDX_W-1:0]  nmps;
    logic [IDX_W-1:0]  nlps;
    logic              sw;
  } prob_row_t;

  typedef struct packed {
    logic             mps;
    logic [IDX_W-1:0] idx;
  } ctx_state_t;

  // Probability estimate, successor on match, successor on mismatch, switch.
  function automatic prob_row_t prob_row(input logic [IDX_W-1:0] i);
    prob_row_t r;
    case (i)
      6'd0:  r = {16'h5601, 6'd1,  6'd1,  1'b1};
      6'd1:  r = {16'h3401, 6'd2,  6'd6,  1'b0};
      6'd2:  r = {16'h1801, 6'd3,  6'd9,  1'b0};
      6'd3:  r = {16'h0AC1, 6'd4,  6'd12, 1'b0};
      6'd4:  r = {16'h0521, 6'd5,  6'd29, 1'b0};
      6'd5:  r = {16'h0221, 6'd38, 6'd33, 1'b0};
      6'd6:  r = {16'h5601, 6'd7,  6'd6,  1'b1};
      6'd7:  r = {16'h5401, 6'd8,  6'd14, 1'b0};
      6'd8:  r = {16'h4801, 6'd9,  6'd14, 1'b0};
      6'd9:  r = {16'h3801, 6'd10, 6'd14, 1'b0};
      6'd10: r = {16'h3001, 6'd11, 6'd17, 1'b0};
      6'd11: r = {16'h2401, 6'd12, 6'd18, 1'b0};
      6'd12: r = {16'h1C01, 6'd13, 6'd20, 1'b0};
      6'd13: r = {16'h1601, 6'd29, 6'd21, 1'b0};
      6'd14: r = {16'h5601, 6'd15, 6'd14, 1'b1};
      6'd15: r = {16'h5401, 6'd16, 6'd14, 1'b0};
      6'd16: r = {16'h5101, 6'd17, 6'd15, 1'b0};
      6'd17: r = {16'h4801, 6'd18, 6'd16, 1'b0};
      6'd18: r = {16'h3801, 6'd19, 6'd17, 1'b0};
      6'd19: r = {16'h3401, 6'd20, 6'd18, 1'b0};
      6'd20: r = {16'h3001, 6'd21, 6'd19, 1'b0};
      6'd21: r = {16'h2801, 6'd22, 6'd19, 1'b0};
      6'd22: r = {16'h2401, 6'd23, 6'd20, 1'b0};
      6'd23: r = {16'h2201, 6'd24, 6'd21, 1'b0};
      6'd24: r = {16'h1C01, 6'd25, 6'd22, 1'b0};
      6'd25: r = {16'h1801, 6'd26, 6'd23, 1'b0};
      6'd26: r = {16'h1601, 6'd27, 6'd24, 1'b0};
      6'd27: r = {16'h1401, 6'd28, 6'd25, 1'b0};
      6'd28: r = {16'h1201, 6'd29, 6'd26, 1'b0};
      6'd29: r = {16'h1101, 6'd30, 6'd27, 1'b0};
      6'd30: r = {16'h0AC1, 6'd31, 6'd28, 1'b0};
      6'd31: r = {16'h09C1, 6'd32, 6'd29, 1'b0};
      6'd32: r = {16'h08A1, 6'd33, 6'd30, 1'b0};
      6'd33: r = {16'h0521, 6'd34, 6'd31, 1'b0};
      6'd34: r = {16'h0441, 6'd35, 6'd32, 1'b0};
      6'd35: r = {16'h02A1, 6'd36, 6'd33, 1'b0};
      6'd36: r = {16'h0221, 6'd37, 6'd34, 1'b0};
      6'd37: r = {16'h0141, 6'd38, 6'd35, 1'b0};
      6'd38: r = {16'h0111, 6'd39, 6'd36, 1'b0};
      6'd39: r = {16'h0085, 6'd40, 6'd37, 1'b0};
      6'd40: r = {16'h0049, 6'd41, 6'd38, 1'b0};
      6'd41: r = {16'h0025, 6'd42, 6'd39, 1'b0};
      6'd42: r = {16'h0015, 6'd43, 6'd40, 1'b0};
      6'd43: r = {16'h0009, 6'd44, 6'd41, 1'b0};
      6'd44: r = {16'h0005, 6'd45, 6'd42, 1'b0};
      6'd45: r = {16'h0001, 6'd45, 6'd43, 1'b0};
      default: r = {16'h5601, 6'd46, 6'd46, 1'b0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ctx_prob_rom.sv
module ctx_prob_rom
  import ctxs_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output prob_row_t        row
);
  always_comb row = prob_row(idx);
endmodule

// File: rtl/ctx_state_store.sv
module ctx_state_store
  import ctxs_pkg::*;
#(
  parameter int CTX_W    = 5,
  parameter int NUM_CTX  = 19,
  parameter int RL_CTX   = 17,
  parameter int UNI_CTX  = 18,
  parameter int RL_INIT  = 3,
  parameter int UNI_INIT = 46
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic [CTX_W-1:0] rd_ctx,
  output ctx_state_t       rd_state,
  input  logic             wr_en,
  input  logic [CTX_W-1:0] wr_ctx,
  input  ctx_state_t       wr_state
);
  ctx_state_t mem [NUM_CTX];

  always_ff @(posedge clk) begin
    if (rst || init) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        mem[c].mps <= 1'b0;
        if (c == UNI_CTX)     mem[c].idx <= IDX_W'(UNI_INIT);
        else if (c == RL_CTX) mem[c].idx <= IDX_W'(RL_INIT);
        else                  mem[c].idx <= '0;
      end
    end else if (wr_en) begin
      mem[wr_ctx] <= wr_state;
    end
  end

  assign rd_state = mem[rd_ctx];
endmodule

// File: rtl/ctx_state_step.sv
module ctx_state_step
  import ctxs_pkg::*;
(
  input  logic       sym,
  input  ctx_state_t cur,
  input  prob_row_t  row,
  output logic       hit,
  output ctx_state_t nxt
);
  always_comb begin
    hit     = (sym == cur.mps);
    nxt.mps = cur.mps ^ (~hit & row.sw);
    nxt.idx = hit ? row.nmps : row.nlps;
  end
endmodule

// File: rtl/ctx_state_bypass.sv
module ctx_state_bypass
  import ctxs_pkg::*;
#(
  parameter int CTX_W    = 5,
  parameter int NUM_CTX  = 19,
  parameter int RL_CTX   = 17,
  parameter int UNI_CTX  = 18,
  parameter int RL_INIT  = 3,
  parameter int UNI_INIT = 46
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CTX_W-1:0]  in_ctx,
  input  logic              in_bit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROB_W-1:0] out_prob,
  output logic              out_is_mps
);
  localparam logic [CTX_W:0]   CTX_LIMIT = (CTX_W+1)'(NUM_CTX);
  localparam logic [CTX_W-1:0] CTX_FOLD  = CTX_W'(UNI_CTX);

  logic             adv, take;
  logic [CTX_W-1:0] ctx_eff;

  // Stage A: label captured, store read
  logic             a_valid, a_bit;
  logic [CTX_W-1:0] a_ctx;
  ctx_state_t       mem_st, a_cur;
  prob_row_t        row_mem, a_row;
  logic             fwd;

  // Stage B: decision resolved, successor computed and written back
  logic             b_valid, b_bit, b_hit;
  logic [CTX_W-1:0] b_ctx;
  ctx_state_t       b_cur, b_nxt;
  prob_row_t        b_row, row_nxt;

  assign adv      = out_ready;
  assign in_ready = out_ready & ~init & ~rst;
  assign take     = in_valid & in_ready;
  assign ctx_eff  = ({1'b0, in_ctx} < CTX_LIMIT) ? in_ctx : CTX_FOLD;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      a_valid <= 1'b0;
    end else if (adv) begin
      a_valid <= take;
      a_ctx   <= ctx_eff;
      a_bit   <= in_bit;
    end
  end

  ctx_state_store #(
    .CTX_W(CTX_W), .NUM_CTX(NUM_CTX), .RL_CTX(RL_CTX), .UNI_CTX(UNI_CTX),
    .RL_INIT(RL_INIT), .UNI_INIT(UNI_INIT)
  ) u_store (
    .clk(clk), .rst(rst), .init(init),
    .rd_ctx(a_ctx), .rd_state(mem_st),
    .wr_en(adv & b_valid), .wr_ctx(b_ctx), .wr_state(b_nxt)
  );

  // First table copy: row of the stored state
  ctx_prob_rom u_rom_mem (.idx(mem_st.idx), .row(row_mem));

  // Same label in stage B: its write has not landed yet, take it from stage B
  assign fwd   = b_valid && (b_ctx == a_ctx);
  assign a_cur = fwd ? b_nxt   : mem_st;
  assign a_row = fwd ? row_nxt : row_mem;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      b_valid <= 1'b0;
    end else if (adv) begin
      b_valid <= a_valid;
      b_ctx   <= a_ctx;
      b_bit   <= a_bit;
      b_cur   <= a_cur;
      b_row   <= a_row;
    end
  end

  ctx_state_step u_step (
    .sym(b_bit), .cur(b_cur), .row(b_row), .hit(b_hit), .nxt(b_nxt)
  );

  // Second table copy: row of the successor state, feeds the forwarding path
  ctx_prob_rom u_rom_nxt (.idx(b_nxt.idx), .row(row_nxt));

  always_ff @(posedge clk) begin
    if (rst || init) begin
      out_valid  <= 1'b0;
      out_prob   <= '0;
      out_is_mps <= 1'b0;
    end else if (adv) begin
      out_valid  <= b_valid;
      out_prob   <= b_row.qe;
      out_is_mps <= b_hit;
    end
  end
endmodule

// File: rtl/ctx_state_bypass_chk.sv
module ctx_state_bypass_chk #(
  parameter int PROB_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              init,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PROB_W-1:0] out_prob,
  input logic              out_is_mps
);
  // R2: accepted input is presented after two advancing edges
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1) &&
     !$past(init, 2) && !$past(init, 1) && !$past(rst, 2) && !$past(rst, 1))
    |-> out_valid);

  // R6: a held output keeps its value
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !init)
    |=> (out_valid && $stable(out_prob) && $stable(out_is_mps)));

  // R6: no input taken while the consumer stalls
  p_ready_r6: assert property (@(posedge clk) disable iff (rst)
    !out_ready |-> !in_ready);

  // R1: reset leaves no output presented
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R7: init flushes the output
  p_init_flush_r7: assert property (@(posedge clk) disable iff (rst)
    $past(init) |-> !out_valid);
endmodule

bind ctx_state_bypass ctx_state_bypass_chk #(.PROB_W(16)) u_chk (
  .clk(clk), .rst(rst), .init(init), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_prob(out_prob),
  .out_is_mps(out_is_mps)
);

// File: tb/sim_ctx_state_bypass.sv
`timescale 1ns/1ps
module sim_ctx_state_bypass;
  localparam int CTX_W = 5;

  logic clk = 1'b0, rst = 1'b1, init = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b1;
  logic [CTX_W-1:0] in_ctx = '0;
  logic in_ready, out_valid, out_is_mps;
  logic [15:0] out_prob;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit bp_on = 1'b0;
  bit done = 1'b0;
  logic [16:0] expq[$];
  int   m_idx[19];
  logic m_mps[19];

  always #2.5 clk = ~clk;

  ctx_state_bypass u0 (
    .clk(clk), .rst(rst), .init(init), .in_valid(in_valid), .in_ready(in_ready),
    .in_ctx(in_ctx), .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_prob(out_prob), .out_is_mps(out_is_mps)
  );

  // Bench copy of the table: {prob[28:13], next_mps[12:7], next_lps[6:1], switch[0]}
  function automatic logic [28:0] tbl(input int i);
    case (i)
      0:  return {16'h5601, 6'd1,  6'd1,  1'b1};
      1:  return {16'h3401, 6'd2,  6'd6,  1'b0};
      2:  return {16'h1801, 6'd3,  6'd9,  1'b0};
      3:  return {16'h0AC1, 6'd4,  6'd12, 1'b0};
      4:  return {16'h0521, 6'd5,  6'd29, 1'b0};
      5:  return {16'h0221, 6'd38, 6'd33, 1'b0};
      6:  return {16'h5601, 6'd7,  6'd6,  1'b1};
      7:  return {16'h5401, 6'd8,  6'd14, 1'b0};
      8:  return {16'h4801, 6'd9,  6'd14, 1'b0};
      9:  return {16'h3801, 6'd10, 6'd14, 1'b0};
      10: return {16'h3001, 6'd11, 6'd17, 1'b0};
      11: return {16'h2401, 6'd12, 6'd18, 1'b0};
      12: return {16'h1C01, 6'd13, 6'd20, 1'b0};
      13: return {16'h1601, 6'd29, 6'd21, 1'b0};
      14: return {16'h5601, 6'd15, 6'd14, 1'b1};
      15: return {16'h5401, 6'd16, 6'd14, 1'b0};
      16: return {16'h5101, 6'd17, 6'd15, 1'b0};
      17: return {16'h4801, 6'd18, 6'd16, 1'b0};
      18: return {16'h3801, 6'd19, 6'd17, 1'b0};
      19: return {16'h3401, 6'd20, 6'd18, 1'b0};
      20: return {16'h3001, 6'd21, 6'd19, 1'b0};
      21: return {16'h2801, 6'd22, 6'd19, 1'b0};
      22: return {16'h2401, 6'd23, 6'd20, 1'b0};
      23: return {16'h2201, 6'd24, 6'd21, 1'b0};
      24: return {16'h1C01, 6'd25, 6'd22, 1'b0};
      25: return {16'h1801, 6'd26, 6'd23, 1'b0};
      26: return {16'h1601, 6'd27, 6'd24, 1'b0};
      27: return {16'h1401, 6'd28, 6'd25, 1'b0};
      28: return {16'h1201, 6'd29, 6'd26, 1'b0};
      29: return {16'h1101, 6'd30, 6'd27, 1'b0};
      30: return {16'h0AC1, 6'd31, 6'd28, 1'b0};
      31: return {16'h09C1, 6'd32, 6'd29, 1'b0};
      32: return {16'h08A1, 6'd33, 6'd30, 1'b0};
      33: return {16'h0521, 6'd34, 6'd31, 1'b0};
      34: return {16'h0441, 6'd35, 6'd32, 1'b0};
      35: return {16'h02A1, 6'd36, 6'd33, 1'b0};
      36: return {16'h0221, 6'd37, 6'd34, 1'b0};
      37: return {16'h0141, 6'd38, 6'd35, 1'b0};
      38: return {16'h0111, 6'd39, 6'd36, 1'b0};
      39: return {16'h0085, 6'd40, 6'd37, 1'b0};
      40: return {16'h0049, 6'd41, 6'd38, 1'b0};
      41: return {16'h0025, 6'd42, 6'd39, 1'b0};
      42: return {16'h0015, 6'd43, 6'd40, 1'b0};
      43: return {16'h0009, 6'd44, 6'd41, 1'b0};
      44: return {16'h0005, 6'd45, 6'd42, 1'b0};
      45: return {16'h0001, 6'd45, 6'd43, 1'b0};
      default: return {16'h5601, 6'd46, 6'd46, 1'b0};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 19; c++) begin m_idx[c] = 0; m_mps[c] = 1'b0; end
    m_idx[17] = 3;
    m_idx[18] = 46;
  endtask

  function automatic logic [16:0] model_step(input int ctx, input logic b);
    int c = (ctx >= 19) ? 18 : ctx;
    logic [28:0] r = tbl(m_idx[c]);
    logic hit = (b == m_mps[c]);
    if (hit) m_idx[c] = int'(r[12:7]);
    else begin
      if (r[0]) m_mps[c] = ~m_mps[c];
      m_idx[c] = int'(r[6:1]);
    end
    return {r[28:13], hit};
  endfunction

  task automatic set_bp();
    if (bp_on) out_ready = (($urandom % 4) != 0);
    else       out_ready = 1'b1;
  endtask

  // Offer one pair from a falling edge; returns at the falling edge after it is taken
  task automatic send(input int ctx, input logic b, input bit use_lit = 1'b0,
                      input logic [16:0] lit = '0);
    logic [16:0] e;
    in_valid = 1'b1; in_ctx = CTX_W'(ctx); in_bit = b;
    set_bp(); #1;
    while (!in_ready) begin @(negedge clk); set_bp(); #1; end
    e = model_step(ctx, b);
    if (use_lit) e = lit;
    expq.push_back(e);
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    in_valid = 1'b0; bp_on = 1'b0; out_ready = 1'b1;
    repeat (6) @(negedge clk);
    check(expq.size() == 0, req, "all outputs delivered", expq.size(), 0);
  endtask

  // Output monitor: compares each handshake just before the rising edge
  always @(negedge clk) begin
    logic [16:0] e;
    #2;
    if (!rst && out_valid && out_ready) begin
      if (expq.size() == 0)
        check(1'b0, cur_req, "unexpected output", {out_prob, out_is_mps}, 0);
      else begin
        e = expq.pop_front();
        check({out_prob, out_is_mps} == e, cur_req, "prob/mps", {out_prob, out_is_mps}, e);
      end
    end
  end

  task automatic t_reset_state();
    cur_req = "R1";
    check(out_valid == 1'b0, "R6", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R6", "in_ready after reset", in_ready, 1);
    send(0, 1'b0, 1'b1, {16'h5601, 1'b1});
    send(17, 1'b0, 1'b1, {16'h0AC1, 1'b1});
    send(18, 1'b1, 1'b1, {16'h5601, 1'b0});
    send(9, 1'b1, 1'b1, {16'h5601, 1'b0});
    drain("R1");
  endtask

  task automatic t_latency();
    cur_req = "R2";
    send(4, 1'b0);
    in_valid = 1'b0; #1;
    check(out_valid == 1'b0, "R2", "valid after 1 edge", out_valid, 0);
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R2", "valid after 2 edges", out_valid, 0);
    @(negedge clk); #1;
    check(out_valid == 1'b1, "R2", "valid after 3 edges", out_valid, 1);
    drain("R2");
  endtask

  task automatic t_table();
    cur_req = "R3";
    send(6, 1'b1, 1'b1, {16'h5601, 1'b0});
    send(6, 1'b1, 1'b1, {16'h3401, 1'b1});
    send(6, 1'b0, 1'b1, {16'h1801, 1'b0});
    send(6, 1'b1, 1'b1, {16'h3801, 1'b1});
    send(6, 1'b0, 1'b1, {16'h3001, 1'b0});
    send(6, 1'b0, 1'b1, {16'h4801, 1'b0});
    drain("R3");
  endtask

  task automatic t_back_to_back();
    realtime t0;
    cur_req = "R4";
    t0 = $realtime;
    for (int k = 0; k < 24; k++) send(10, (k % 3) == 0);
    check(($realtime - t0) == 120.0, "R4", "no stall cycles (ns)", int'($realtime - t0), 120);
    drain("R4");
  endtask

  task automatic t_one_apart();
    cur_req = "R5";
    for (int k = 0; k < 30; k++) send((k % 2) ? 12 : 11, ($urandom % 3) == 0);
    send(11, 1'b1); send(12, 1'b0); send(12, 1'b1); send(11, 1'b0);
    send(13, 1'b1); send(11, 1'b1);
    drain("R5");
  endtask

  task automatic t_backpressure();
    logic [15:0] p; logic m;
    cur_req = "R6";
    send(3, 1'b1); send(3, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b0; #1;
    p = out_prob; m = out_is_mps;
    check(out_valid == 1'b1, "R6", "output presented before stall", out_valid, 1);
    in_valid = 1'b1; in_ctx = 5'd3; in_bit = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      check(out_valid == 1'b1, "R6", "valid held", out_valid, 1);
      check({out_prob, out_is_mps} == {p, m}, "R6", "data held", {out_prob, out_is_mps}, {p, m});
      check(in_ready == 1'b0, "R6", "in_ready low in stall", in_ready, 0);
    end
    in_valid = 1'b0;
    drain("R6");
  endtask

  task automatic t_init();
    cur_req = "R7";
    send(8, 1'b1); send(8, 1'b1);
    in_valid = 1'b0;
    init = 1'b1; #1;
    check(in_ready == 1'b0, "R7", "in_ready during init", in_ready, 0);
    expq.delete();
    model_reset();
    @(negedge clk);
    init = 1'b0;
    repeat (3) begin
      #1;
      check(out_valid == 1'b0, "R7", "flushed entry", out_valid, 0);
      @(negedge clk);
    end
    send(6, 1'b1, 1'b1, {16'h5601, 1'b0});
    send(17, 1'b1, 1'b1, {16'h0AC1, 1'b0});
    drain("R7");
  endtask

  task automatic t_range();
    cur_req = "R8";
    send(31, 1'b1, 1'b1, {16'h5601, 1'b0});
    send(19, 1'b0, 1'b1, {16'h5601, 1'b1});
    send(18, 1'b1, 1'b1, {16'h5601, 1'b0});
    send(0, 1'b0, 1'b1, {16'h5601, 1'b1});
    send(1, 1'b1, 1'b1, {16'h5601, 1'b0});
    drain("R8");
  endtask

  task automatic t_random();
    int last = 0;
    int pool[5] = '{0, 1, 2, 17, 25};
    cur_req = "R9";
    bp_on = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      int c = (($urandom % 2) == 0) ? last : pool[$urandom % 5];
      last = c;
      send(c, ($urandom % 4) == 0 ? 1'b1 : ((k % 7) == 0));
    end
    drain("R9");
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      check(1'b0, "R9", "watchdog", 1, 0);
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset_state();
    t_latency();
    t_table();
    t_back_to_back();
    t_one_apart();
    t_backpressure();
    t_init();
    t_range();
    t_random();
    finish_run();
  end
endmodule